// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block is the digital control core of a successive-approximation converter. Software writes a control word that holds a resolution select (8 or 10 bits), a sample-time select, a 5-bit prescaler value and a 2-bit debug-freeze policy. A separate start strobe begins one conversion. The peripheral clock is divided into a slower converter clock. Each conversion then runs through a fixed transfer phase of 8 converter clocks, a final sample phase of programmable length, and one decision clock per result bit. During the decision phase the trial code goes out to the external DAC and comparator. The comparator's digital answer comes back on `cmp_hi`, and the finished code is latched into the result register together with a done flag.

The state machine has five states. `ST_IDLE` waits for a start. `ST_ARMED` holds an accepted start while debug freeze blocks it. `ST_XFER` is the transfer phase, `ST_SAMPLE` the final sample phase and `ST_DECIDE` the bit decisions. The transitions are:
- IDLE→XFER on a start with no freeze pending.
- IDLE→ARMED on a start while debug is active under policy 10 or 11.
- ARMED→XFER when the freeze releases.
- XFER→SAMPLE after the 8th converter clock.
- SAMPLE→DECIDE after the last sample clock.
- DECIDE→IDLE after the LSB decision, with the result loaded.
- Any busy state→IDLE on a control-word write, which is the abort.

While debug is active, policy 11 stops every counter. A control-word write (`cfg_wr`) takes priority over a start strobe in the same cycle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the prescaler value is 1, the resolution is 8 bits, the sample code is 00 and the freeze policy is 00. `busy`, `done`, `sampling`, `result` and `dac_code` are all 0, and a start with these defaults completes in 72 clock cycles.
- R2: With prescaler value N (0..31), one converter clock lasts 2·(N+1) peripheral clock cycles. The done flag rises exactly T·2·(N+1) cycles after the clock edge that accepts the start, where T is the conversion length in converter clocks.
- R3: In 8-bit mode (`cfg_res10`=0), T is 18, 20, 24 or 32 for sample codes 00, 01, 10 and 11. The sample phase lasts 2, 4, 8 or 16 converter clocks and `sampling` is high during it.
- R4: In 10-bit mode (`cfg_res10`=1), T is 20, 22, 26 or 34 for sample codes 00, 01, 10 and 11.
- R5: Bits are decided from MSB to LSB, one per converter clock. During each decision `dac_code` holds the bits kept so far plus the bit under test. A bit is kept when `cmp_hi` is 1. The result is right-aligned, and bits 9:8 are 0 in 8-bit mode.
- R6: `done` goes high when the result is loaded. It is cleared by an accepted start or by an abort, and it is never high while `busy` is high.
- R7: A `cfg_wr` while `busy` is high aborts the conversion. `busy` is low on the next cycle and no result is produced until a new start. A start strobe while `busy` is high is ignored.
- R8: With freeze policy 00 or 01, `dbg_active` has no effect on timing or result.
- R9: With freeze policy 11, every cycle with `dbg_active` high freezes the prescaler, the phase counters and the SAR. The conversion resumes where it stopped and ends exactly that many cycles late. A start given while debug is active waits until it drops.
- R10: With freeze policy 10, a conversion already running when debug becomes active finishes on time. A start given while debug is active stays pending with `busy` high and begins on the first edge after `dbg_active` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control-word write strobe (aborts a busy conversion) |
| cfg_res10 | input | 1 | Resolution: 0 = 8 bits, 1 = 10 bits |
| cfg_smp | input | 2 | Sample-time code |
| cfg_prs | input | 5 | Prescaler value N |
| cfg_frz | input | 2 | Debug freeze policy |
| start_wr | input | 1 | Start strobe |
| dbg_active | input | 1 | Background debug active |
| cmp_hi | input | 1 | Comparator decision for the current trial code |
| busy | output | 1 | Conversion accepted and not finished |
| sampling | output | 1 | Final sample phase in progress |
| dac_code | output | 10 | Trial code to the DAC |
| result | output | 10 | Last conversion result |
| done | output | 1 | Result valid |

## Verification
Conversions run against a comparator model that answers whether the trial code is at or below a chosen target. Targets of all zeros, all ones, alternating bits and a lone MSB separate a wrong bit order or keep rule from a correct one. Every pairing of resolution and sample code is tried, each under a different prescaler value, so an error in the divide ratio, the sample length or the bit count shows up as a cycle-exact timing mismatch. Debug pulses are applied under each freeze policy, both in mid-conversion and before a start. Under policy 11 the measured lateness must equal the pulse length. Under the other policies it must be zero, and only a pending start waits.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_XFER,
        ST_SAMPLE,
        ST_DECIDE
    } seq_state_t;

    localparam logic [1:0] FRZ_RUN  = 2'b00;
    localparam logic [1:0] FRZ_RSVD = 2'b01;
    localparam logic [1:0] FRZ_END  = 2'b10;
    localparam logic [1:0] FRZ_NOW  = 2'b11;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             half_q;
    logic             wrap;

    assign wrap = (cnt_q >= div_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (!hold) begin
            if (wrap) begin
                cnt_q  <= '0;
                half_q <= ~half_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick = !clr && !hold && half_q && wrap;

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> ($stable(cnt_q) && $stable(half_q))); // R9
    AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !half_q)); // R2
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int HI_BITS   = 10,
    parameter int LO_BITS   = 8,
    parameter int XFER_CLKS = 8,
    parameter int PH_W      = 5,
    localparam int IDX_W    = $clog2(HI_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             park,
    input  logic             hold,
    input  logic             tick,
    input  logic             res10,
    input  logic [1:0]       smp,
    output logic             busy,
    output logic             run,
    output logic             sampling,
    output logic             accept,
    output logic             dec_step,
    output logic             dec_last,
    output logic [IDX_W-1:0] bit_idx
);
    seq_state_t       state_q, state_d;
    logic [PH_W-1:0]  ph_cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [PH_W-1:0]  smp_last;
    logic [PH_W-1:0]  xfer_last;
    logic [IDX_W-1:0] msb_idx;

    assign smp_last  = PH_W'((2 << smp) - 1);
    assign xfer_last = PH_W'(XFER_CLKS - 1);
    assign msb_idx   = res10 ? IDX_W'(HI_BITS - 1) : IDX_W'(LO_BITS - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && !abort) state_d = park ? ST_ARMED : ST_XFER;
            end
            ST_ARMED: begin
                if (abort)      state_d = ST_IDLE;
                else if (!park) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (abort) state_d = ST_IDLE;
                else if (tick && ph_cnt_q == xfer_last) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (abort) state_d = ST_IDLE;
                else if (tick && ph_cnt_q == smp_last) state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (abort) state_d = ST_IDLE;
                else if (tick && idx_q == '0) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt_q <= '0;
            idx_q    <= '0;
        end else begin
            if (state_q != state_d) ph_cnt_q <= '0;
            else if (tick)          ph_cnt_q <= ph_cnt_q + 1'b1;

            if (state_q == ST_SAMPLE && state_d == ST_DECIDE)
                idx_q <= msb_idx;
            else if (state_q == ST_DECIDE && tick && idx_q != '0)
                idx_q <= idx_q - 1'b1;
        end
    end

    always_comb begin
        busy     = 1'b0;
        run      = 1'b0;
        sampling = 1'b0;
        dec_step = 1'b0;
        accept   = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept = start && !abort;
            ST_ARMED:  busy = 1'b1;
            ST_XFER: begin
                busy = 1'b1;
                run  = 1'b1;
            end
            ST_SAMPLE: begin
                busy     = 1'b1;
                run      = 1'b1;
                sampling = 1'b1;
            end
            ST_DECIDE: begin
                busy     = 1'b1;
                run      = 1'b1;
                dec_step = tick && !abort;
            end
            default: ;
        endcase
        dec_last = dec_step && (idx_q == '0);
        bit_idx  = idx_q;
    end

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> (state_q == ST_IDLE)); // R7
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !abort) |=> ($stable(state_q) && $stable(ph_cnt_q) && $stable(idx_q))); // R9
    AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |-> (idx_q <= msb_idx)); // R5
    AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |-> (ph_cnt_q <= smp_last)); // R3
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int HI_BITS = 10,
    localparam int IDX_W  = $clog2(HI_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               deciding,
    input  logic               step,
    input  logic               last,
    input  logic [IDX_W-1:0]   idx,
    input  logic               cmp_hi,
    input  logic               done_clr,
    output logic [HI_BITS-1:0] trial,
    output logic [HI_BITS-1:0] result,
    output logic               done
);
    logic [HI_BITS-1:0] sar_q;
    logic [HI_BITS-1:0] probe;
    logic [HI_BITS-1:0] sar_next;

    assign probe    = {{(HI_BITS-1){1'b0}}, 1'b1} << idx;
    assign sar_next = cmp_hi ? (sar_q | probe) : sar_q;
    assign trial    = deciding ? (sar_q | probe) : sar_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            if (clr)       sar_q <= '0;
            else if (step) sar_q <= sar_next;

            if (last) result <= sar_next;

            if (done_clr)  done <= 1'b0;
            else if (last) done <= 1'b1;
        end
    end

    AST_DONE_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(last)); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(result)); // R5
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int HI_BITS   = 10,
    parameter int LO_BITS   = 8,
    parameter int DIV_W     = 5,
    parameter int XFER_CLKS = 8,
    parameter int PH_W      = 5,
    localparam int IDX_W    = $clog2(HI_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_res10,
    input  logic [1:0]         cfg_smp,
    input  logic [DIV_W-1:0]   cfg_prs,
    input  logic [1:0]         cfg_frz,
    input  logic               start_wr,
    input  logic               dbg_active,
    input  logic               cmp_hi,
    output logic               busy,
    output logic               sampling,
    output logic [HI_BITS-1:0] dac_code,
    output logic [HI_BITS-1:0] result,
    output logic               done
);
    logic             res10_q;
    logic [1:0]       smp_q;
    logic [DIV_W-1:0] prs_q;
    logic [1:0]       frz_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res10_q <= 1'b0;
            smp_q   <= 2'b00;
            prs_q   <= DIV_W'(1);
            frz_q   <= FRZ_RUN;
        end else if (cfg_wr) begin
            res10_q <= cfg_res10;
            smp_q   <= cfg_smp;
            prs_q   <= cfg_prs;
            frz_q   <= cfg_frz;
        end
    end

    logic             park;
    logic             hold;
    logic             tick;
    logic             run;
    logic             accept;
    logic             dec_step;
    logic             dec_last;
    logic [IDX_W-1:0] bit_idx;
    logic             in_decide;

    assign park = dbg_active && (frz_q == FRZ_END || frz_q == FRZ_NOW);
    assign hold = dbg_active && (frz_q == FRZ_NOW) && busy;

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .hold  (hold),
        .div_n (prs_q),
        .tick  (tick)
    );

    adc_seq_fsm #(
        .HI_BITS   (HI_BITS),
        .LO_BITS   (LO_BITS),
        .XFER_CLKS (XFER_CLKS),
        .PH_W      (PH_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_wr),
        .abort    (cfg_wr),
        .park     (park),
        .hold     (hold),
        .tick     (tick),
        .res10    (res10_q),
        .smp      (smp_q),
        .busy     (busy),
        .run      (run),
        .sampling (sampling),
        .accept   (accept),
        .dec_step (dec_step),
        .dec_last (dec_last),
        .bit_idx  (bit_idx)
    );

    assign in_decide = run && !sampling && (bit_idx != '0 || dec_step || busy) &&
                       (u_fsm.state_q == ST_DECIDE);

    adc_sar_reg #(.HI_BITS(HI_BITS)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .deciding (in_decide),
        .step     (dec_step),
        .last     (dec_last),
        .idx      (bit_idx),
        .cmp_hi   (cmp_hi),
        .done_clr (accept || (cfg_wr && busy)),
        .trial    (dac_code),
        .result   (result),
        .done     (done)
    );

    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R6
    AST_NARROW_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_last && !res10_q) |=> (result[HI_BITS-1:LO_BITS] == '0)); // R5
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_res10 = 1'b0;
    logic [1:0] cfg_smp = 2'b00;
    logic [4:0] cfg_prs = 5'd1;
    logic [1:0] cfg_frz = 2'b00;
    logic       start_wr = 1'b0;
    logic       dbg_active = 1'b0;
    logic       cmp_hi;
    logic       busy, sampling, done;
    logic [9:0] dac_code, result;

    int target = 0;
    int cyc = 0;
    int errors = 0;
    int checks = 0;

    int sh_res = 0;
    int sh_smp = 0;
    int sh_prs = 1;

    typedef struct {
        int    res;
        int    when;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    assign cmp_hi = (int'(dac_code) <= target);

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_res10(cfg_res10),
        .cfg_smp(cfg_smp), .cfg_prs(cfg_prs), .cfg_frz(cfg_frz),
        .start_wr(start_wr), .dbg_active(dbg_active), .cmp_hi(cmp_hi),
        .busy(busy), .sampling(sampling), .dac_code(dac_code),
        .result(result), .done(done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n && done && !prev_done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(int'(result) == e.res, {e.tag, " result"}, int'(result), e.res);
                chk(cyc == e.when, {e.tag, " done cycle"}, cyc, e.when);
            end
        end
        prev_done = done;
    end

    function automatic int conv_cycles();
        int t;
        t = 8 + (2 << sh_smp) + (sh_res != 0 ? 10 : 8);
        return t * 2 * (sh_prs + 1);
    endfunction

    task automatic write_cfg(input int res, input int smp, input int prs, input int frz);
        @(negedge clk);
        cfg_res10 = res[0];
        cfg_smp   = smp[1:0];
        cfg_prs   = prs[4:0];
        cfg_frz   = frz[1:0];
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        sh_res = res; sh_smp = smp; sh_prs = prs;
    endtask

    task automatic start_raw();
        @(negedge clk);
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
    endtask

    task automatic push_exp(input int res, input int base, input int extra, input string tag);
        exp_t e;
        e.res  = res;
        e.when = base + conv_cycles() + extra;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic start_conv(input int tgt, input int extra, input string tag);
        target = tgt;
        start_raw();
        push_exp(tgt, cyc, extra, tag);
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 20000 && sb.size() != 0; i++) @(negedge clk);
        chk(sb.size() == 0, {tag, " completion"}, sb.size(), 0);
        chk(done == 1'b1, {tag, " done high"}, int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", int'(busy), 0);
        chk(done == 0, "R1 done", int'(done), 0);
        chk(sampling == 0, "R1 sampling", int'(sampling), 0);
        chk(result == 0, "R1 result", int'(result), 0);
        chk(dac_code == 0, "R1 dac_code", int'(dac_code), 0);

        // R1 default config: 18 clocks x 4 cycles
        start_conv(8'hA5, 0, "R1 default");
        for (int i = 0; i < 4; i++) @(negedge clk);
        for (int i = 0; i < 40 && !sampling; i++) @(negedge clk);
        chk(sampling == 1, "R3 sampling phase seen", int'(sampling), 1);
        wait_done("R1 default");

        // R6 start clears done
        start_conv(8'h5A, 0, "R6 restart");
        chk(done == 0, "R6 done cleared by start", int'(done), 0);
        wait_done("R6 restart");

        // R2 R3 8-bit sample codes with varied prescaler
        write_cfg(0, 1, 0, 0);  start_conv(8'h00, 0, "R3 smp01 N0");  wait_done("R3 a");
        write_cfg(0, 2, 3, 0);  start_conv(8'hFF, 0, "R3 smp10 N3");  wait_done("R3 b");
        write_cfg(0, 3, 7, 0);  start_conv(8'h3C, 0, "R2 smp11 N7");  wait_done("R2 a");
        write_cfg(0, 0, 31, 0); start_conv(8'h80, 0, "R2 smp00 N31"); wait_done("R2 b");

        // R4 R5 10-bit
        write_cfg(1, 0, 2, 0); start_conv(10'h3FF, 0, "R4 smp00"); wait_done("R4 a");
        write_cfg(1, 1, 0, 0); start_conv(10'h000, 0, "R4 smp01"); wait_done("R4 b");
        write_cfg(1, 2, 5, 0); start_conv(10'h201, 0, "R5 smp10"); wait_done("R5 a");
        write_cfg(1, 3, 1, 0); start_conv(10'h155, 0, "R5 smp11"); wait_done("R5 b");

        // R7 start while busy is ignored
        write_cfg(0, 0, 1, 0);
        start_conv(8'h33, 0, "R7 restart ignored");
        repeat (20) @(negedge clk);
        start_raw();
        wait_done("R7 restart ignored");

        // R7 abort by control write
        target = 8'h77;
        start_raw();
        repeat (30) @(negedge clk);
        write_cfg(0, 0, 1, 0);
        chk(busy == 0, "R7 busy after abort", int'(busy), 0);
        chk(done == 0, "R6 done after abort", int'(done), 0);
        repeat (300) @(negedge clk);
        chk(busy == 0, "R7 stays idle", int'(busy), 0);
        chk(done == 0, "R7 no result", int'(done), 0);
        start_conv(8'h77, 0, "R7 after abort"); wait_done("R7 after abort");

        // R8 policies 00 and 01 ignore debug
        write_cfg(0, 1, 2, 0);
        start_conv(8'h19, 0, "R8 policy00");
        repeat (10) @(negedge clk);
        dbg_active = 1'b1; repeat (40) @(negedge clk); dbg_active = 1'b0;
        wait_done("R8 policy00");
        write_cfg(1, 1, 2, 1);
        dbg_active = 1'b1;
        start_conv(10'h2C3, 0, "R8 policy01");
        wait_done("R8 policy01");
        dbg_active = 1'b0;

        // R9 policy 11 freezes mid conversion
        write_cfg(1, 2, 1, 3);
        start_conv(10'h1E7, 37, "R9 freeze mid");
        repeat (90) @(negedge clk);
        begin
            logic [9:0] snap;
            snap = dac_code;
            dbg_active = 1'b1;
            repeat (37) @(negedge clk);
            chk(dac_code == snap, "R9 dac held", int'(dac_code), int'(snap));
            chk(busy == 1, "R9 busy held", int'(busy), 1);
            dbg_active = 1'b0;
        end
        wait_done("R9 freeze mid");

        // R9 start under policy 11 waits
        dbg_active = 1'b1;
        target = 10'h0F0;
        start_raw();
        repeat (50) @(negedge clk);
        chk(busy == 1, "R9 pending busy", int'(busy), 1);
        chk(done == 0, "R9 pending no done", int'(done), 0);
        dbg_active = 1'b0;
        push_exp(10'h0F0, cyc + 1, 0, "R9 pending start");
        wait_done("R9 pending start");

        // R10 policy 10: finish current, hold next
        write_cfg(0, 3, 0, 2);
        start_conv(8'hC8, 0, "R10 finish on time");
        repeat (20) @(negedge clk);
        dbg_active = 1'b1;
        wait_done("R10 finish on time");
        target = 8'h4B;
        start_raw();
        chk(done == 0, "R6 done cleared by pending start", int'(done), 0);
        repeat (60) @(negedge clk);
        chk(busy == 1, "R10 pending busy", int'(busy), 1);
        chk(done == 0, "R10 pending no done", int'(done), 0);
        dbg_active = 1'b0;
        push_exp(8'h4B, cyc + 1, 0, "R10 pending start");
        wait_done("R10 pending start");

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule